// File: doc/BRIEF.md
# TDM 32-to-24 Channel Compressor

This block takes a serial time-division multiplexed stream framed as 32 eight-bit timeslots (256 bits per frame) and produces a serial stream framed as 193 bits: a framing bit followed by 24 eight-bit channels. A 32-bit drop mask chooses which input timeslots are discarded. The timeslots that are kept are packed in ascending order into the 24 output channels, and the framing-bit position is always driven high.

Each side has its own bit strobe. `in_en` qualifies an input bit and `out_en` advances the output serializer, so the two rates can differ while sharing one clock. The block stores one complete input frame. When an input frame finishes, its packed image becomes pending. The next output frame that starts after that picks up the pending image, so the output runs one frame behind the input. The mask is written one byte at a time through a small write port. A write lands in a shadow copy, and that copy is applied only at the start of the next input frame.

Top module: `tdm_ch_compress`

## Requirements
- R1: Mask byte at `reg_addr` = a (0..3) holds the drop bits for input timeslots 8a+1 to 8a+8, bit j of the byte mapping to timeslot 8a+j+1. A bit value of 1 drops that timeslot and 0 keeps it.
- R2: After reset the mask is 0xFF000000 (timeslots 25 to 32 dropped), so input timeslots 1 to 24 appear unchanged as output channels 1 to 24.
- R3: Kept timeslots fill output channels 1, 2, 3 and onward in ascending timeslot order. Bits are sent MSb first on both sides. Output bit 1+8(k-1)+j carries bit 7-j of output channel k.
- R4: Output bit 0 of every frame is the framing bit. It is always 1, and `out_sync` is high in exactly the cycle in which that bit appears on `out_bit`.
- R5: An output frame is 193 `out_en` strobes long, so `out_sync` recurs every 193 strobes and is never high in two consecutive cycles.
- R6: When fewer than 24 timeslots are kept, every output channel beyond the last kept timeslot is all ones.
- R7: When more than 24 timeslots are kept, only the first 24 in ascending order are carried and the rest are discarded.
- R8: A mask write goes to the shadow copy at once, but the mask used for mapping changes only at an input frame start. A write during a frame therefore affects the following frame and not the current one.
- R9: The image of a completed input frame is emitted by the next output frame that begins after the input frame completes. Before any input frame completes, the output data is all ones. In reset, `out_bit` is 1 and `out_sync` is 0.
- R10: An input bit with `in_sync` and `in_en` both high is the MSb of timeslot 1 and restarts the input bit count. A frame completes after 256 strobed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Input bit strobe |
| in_sync | input | 1 | Marks the first bit of an input frame (valid with in_en) |
| in_bit | input | 1 | Serial input data |
| out_en | input | 1 | Output bit strobe |
| out_bit | output | 1 | Serial output data, registered |
| out_sync | output | 1 | High with the framing bit of each output frame |
| reg_wr_en | input | 1 | Mask byte write strobe |
| reg_addr | input | 2 | Mask byte select |
| reg_wr_data | input | 8 | Mask byte value |

## Verification
A stale or mistimed active mask shows up at the ports as channels shifted or filled with ones, one output frame after the affected input frame. This is the case that the mid-frame write test targets. A wrong bit count on the input side misplaces every bit of the next output image. A wrong count on the output side moves `out_sync` away from the 193-strobe spacing within two output frames. A wrong padding rule or a wrong truncation rule shows in the tail channels of the very next output frame, under masks that keep few or many timeslots.

// File: rtl/tdm_cc_pkg.sv
package tdm_cc_pkg;
    parameter int TS_BITS   = 8;
    parameter int IN_SLOTS  = 32;
    parameter int OUT_CHANS = 24;
    parameter int REG_W     = 8;

    localparam int NUM_REGS       = IN_SLOTS / REG_W;
    localparam int REG_ADDR_W     = $clog2(NUM_REGS);
    localparam int IN_FRAME_BITS  = IN_SLOTS * TS_BITS;
    localparam int OUT_FRAME_BITS = OUT_CHANS * TS_BITS + 1;
    localparam int IN_CNT_W       = $clog2(IN_FRAME_BITS);
    localparam int OUT_CNT_W      = $clog2(OUT_FRAME_BITS);
    localparam int BIT_IDX_W      = $clog2(TS_BITS);
    localparam int SLOT_W         = $clog2(IN_SLOTS);
    localparam int CH_W           = $clog2(OUT_CHANS);

    typedef logic [TS_BITS-1:0]      slot_t;
    typedef slot_t [IN_SLOTS-1:0]    in_frame_t;
    typedef slot_t [OUT_CHANS-1:0]   out_frame_t;
    typedef logic [IN_SLOTS-1:0]     mask_t;

    typedef struct packed {
        logic                  valid;
        logic [REG_ADDR_W-1:0] addr;
        logic [REG_W-1:0]      data;
    } reg_wr_t;

    typedef struct packed {
        logic                start;
        logic                last;
        logic [SLOT_W-1:0]   slot;
        logic [BIT_IDX_W-1:0] bitpos;
    } in_pos_t;

    function automatic mask_t reset_mask();
        mask_t r;
        for (int i = 0; i < IN_SLOTS; i++) begin
            r[i] = (i >= OUT_CHANS);
        end
        return r;
    endfunction

    localparam mask_t MASK_RESET = reset_mask();

    // Pack kept slots in ascending order; unused channels stay all ones.
    function automatic out_frame_t pack_frame(in_frame_t f, mask_t m);
        out_frame_t o;
        int k;
        o = '1;
        k = 0;
        for (int t = 0; t < IN_SLOTS; t++) begin
            if (!m[t]) begin
                if (k < OUT_CHANS) begin
                    o[k] = f[t];
                end
                k = k + 1;
            end
        end
        return o;
    endfunction
endpackage

// File: rtl/tdm_cc_maskregs.sv
module tdm_cc_maskregs
    import tdm_cc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr,
    input  logic    frame_start,
    output mask_t   shadow,
    output mask_t   active
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[g*REG_W +: REG_W] <= MASK_RESET[g*REG_W +: REG_W];
            end else if (wr.valid && (wr.addr == REG_ADDR_W'(g))) begin
                shadow[g*REG_W +: REG_W] <= wr.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= MASK_RESET;
        end else if (frame_start) begin
            active <= shadow;
        end
    end
endmodule

// File: rtl/tdm_cc_capture.sv
module tdm_cc_capture
    import tdm_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_en,
    input  logic      in_sync,
    input  logic      in_bit,
    output in_frame_t frame,
    output logic      frame_start,
    output logic      frame_done
);
    logic [IN_CNT_W-1:0] cnt;
    logic [IN_CNT_W-1:0] pos;
    in_pos_t             p;

    always_comb begin
        pos      = in_sync ? '0 : cnt;
        p.start  = in_en && in_sync;
        p.last   = in_en && (pos == IN_CNT_W'(IN_FRAME_BITS - 1));
        p.slot   = pos[IN_CNT_W-1:BIT_IDX_W];
        p.bitpos = BIT_IDX_W'(TS_BITS - 1) - pos[BIT_IDX_W-1:0];
    end

    assign frame_start = p.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            frame      <= '1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= p.last;
            if (in_en) begin
                frame[p.slot][p.bitpos] <= in_bit;
                cnt <= p.last ? '0 : pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdm_cc_packer.sv
module tdm_cc_packer
    import tdm_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  in_frame_t  frame,
    input  mask_t      mask,
    input  logic       frame_done,
    output out_frame_t pending
);
    out_frame_t packed_now;

    always_comb begin
        packed_now = pack_frame(frame, mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '1;
        end else if (frame_done) begin
            pending <= packed_now;
        end
    end
endmodule

// File: rtl/tdm_cc_emitter.sv
module tdm_cc_emitter
    import tdm_cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       out_en,
    input  out_frame_t pending,
    output logic       out_bit,
    output logic       out_sync
);
    logic [OUT_CNT_W-1:0] ocnt;
    logic [OUT_CNT_W-1:0] didx;
    logic [CH_W-1:0]      ch;
    logic [BIT_IDX_W-1:0] bsel;
    out_frame_t           play;
    logic                 at_fbit;
    logic                 at_end;

    always_comb begin
        didx    = ocnt - 1'b1;
        ch      = CH_W'(didx >> BIT_IDX_W);
        bsel    = BIT_IDX_W'(TS_BITS - 1) - didx[BIT_IDX_W-1:0];
        at_fbit = (ocnt == '0);
        at_end  = (ocnt == OUT_CNT_W'(OUT_FRAME_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ocnt     <= '0;
            play     <= '1;
            out_bit  <= 1'b1;
            out_sync <= 1'b0;
        end else if (out_en) begin
            if (at_fbit) begin
                play     <= pending;
                out_bit  <= 1'b1;
                out_sync <= 1'b1;
                ocnt     <= OUT_CNT_W'(1);
            end else begin
                out_bit  <= play[ch][bsel];
                out_sync <= 1'b0;
                ocnt     <= at_end ? '0 : ocnt + 1'b1;
            end
        end else begin
            out_sync <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_ch_compress.sv
module tdm_ch_compress
    import tdm_cc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_en,
    input  logic                  in_sync,
    input  logic                  in_bit,
    input  logic                  out_en,
    output logic                  out_bit,
    output logic                  out_sync,
    input  logic                  reg_wr_en,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wr_data
);
    reg_wr_t    wr;
    mask_t      shadow_mask;
    mask_t      act_mask;
    in_frame_t  cap_frame;
    logic       frame_start;
    logic       frame_done;
    out_frame_t pending;

    always_comb begin
        wr.valid = reg_wr_en;
        wr.addr  = reg_addr;
        wr.data  = reg_wr_data;
    end

    tdm_cc_maskregs u_mask (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .frame_start (frame_start),
        .shadow      (shadow_mask),
        .active      (act_mask)
    );

    tdm_cc_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .in_en       (in_en),
        .in_sync     (in_sync),
        .in_bit      (in_bit),
        .frame       (cap_frame),
        .frame_start (frame_start),
        .frame_done  (frame_done)
    );

    tdm_cc_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .frame      (cap_frame),
        .mask       (act_mask),
        .frame_done (frame_done),
        .pending    (pending)
    );

    tdm_cc_emitter u_emit (
        .clk      (clk),
        .rst      (rst),
        .out_en   (out_en),
        .pending  (pending),
        .out_bit  (out_bit),
        .out_sync (out_sync)
    );
endmodule

// File: rtl/tdm_cc_checker.sv
module tdm_cc_checker
    import tdm_cc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_en,
    input logic                  in_sync,
    input logic                  out_en,
    input logic                  out_bit,
    input logic                  out_sync,
    input logic                  reg_wr_en,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]      reg_wr_data,
    input mask_t                 shadow_mask,
    input mask_t                 act_mask
);
    function automatic logic [REG_W-1:0] byte_of(mask_t m, logic [REG_ADDR_W-1:0] a);
        return m[REG_W*int'(a) +: REG_W];
    endfunction

    // R4: framing bit is high whenever the sync marker is shown
    a_r4_fbit_one: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_bit);

    // R4: sync only follows an output strobe
    a_r4_sync_needs_en: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> $past(out_en));

    // R5: sync is a single-cycle marker
    a_r5_sync_single: assert property (@(posedge clk) disable iff (rst)
        out_sync |=> !out_sync);

    // R1: a written byte lands in the shadow copy
    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> byte_of(shadow_mask, $past(reg_addr)) == $past(reg_wr_data));

    // R8: active mask holds between input frame starts
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_en && in_sync) |=> $stable(act_mask));

    // R8: at a frame start the active mask takes the shadow copy
    a_r8_mask_load: assert property (@(posedge clk) disable iff (rst)
        (in_en && in_sync) |=> act_mask == $past(shadow_mask));
endmodule

bind tdm_ch_compress tdm_cc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_en       (in_en),
    .in_sync     (in_sync),
    .out_en      (out_en),
    .out_bit     (out_bit),
    .out_sync    (out_sync),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .shadow_mask (shadow_mask),
    .act_mask    (act_mask)
);

// File: tb/tb_tdm_ch_compress.sv
module tb_tdm_ch_compress;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_en, in_sync, in_bit, out_en;
    logic       out_bit, out_sync;
    logic       reg_wr_en;
    logic [1:0] reg_addr;
    logic [7:0] reg_wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    tdm_ch_compress dut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_sync(in_sync), .in_bit(in_bit),
        .out_en(out_en), .out_bit(out_bit), .out_sync(out_sync),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wr_data(reg_wr_data)
    );

    typedef logic [31:0][7:0] ifr_t;
    typedef logic [23:0][7:0] ofr_t;

    function automatic ofr_t ref_pack(ifr_t f, logic [31:0] m);
        ofr_t r;
        int t = 0;
        for (int k = 0; k < 24; k++) begin
            while (t < 32 && m[t]) t++;
            if (t < 32) begin
                r[k] = f[t];
                t++;
            end else begin
                r[k] = 8'hFF;
            end
        end
        return r;
    endfunction

    function automatic logic [192:0] to_bits(ofr_t r);
        logic [192:0] b;
        b[0] = 1'b1;
        for (int k = 0; k < 24; k++)
            for (int j = 0; j < 8; j++)
                b[1 + 8*k + j] = r[k][7-j];
        return b;
    endfunction

    function automatic ifr_t rand_frame();
        ifr_t f;
        for (int t = 0; t < 32; t++) f[t] = 8'($urandom);
        return f;
    endfunction

    task automatic check(bit ok, string req, string what, logic [192:0] act, logic [192:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic set_mask(logic [31:0] m);
        for (int a = 0; a < 4; a++) write_reg(2'(a), m[8*a +: 8]);
    endtask

    // R10: bit p of the frame is bit 7-(p%8) of timeslot p/8, sync on p=0
    task automatic send_frame(ifr_t f, int wr_pos, logic [1:0] wa, logic [7:0] wd);
        @(negedge clk);
        for (int p = 0; p < 256; p++) begin
            in_en = 1; in_sync = (p == 0); in_bit = f[p/8][7 - p%8];
            reg_wr_en = (p == wr_pos); reg_addr = wa; reg_wr_data = wd;
            @(posedge clk); #2;
        end
        in_en = 0; in_sync = 0; reg_wr_en = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_garbage(int n);
        @(negedge clk);
        for (int p = 0; p < n; p++) begin
            in_en = 1; in_sync = 0; in_bit = 1'($urandom);
            @(posedge clk); #2;
        end
        in_en = 0;
    endtask

    task automatic recv_check(string req, logic [192:0] exp, bit keep_on);
        logic [192:0] got;
        logic [192:0] syn;
        logic [192:0] syn_exp;
        syn_exp = 193'd1;
        if (!out_en) @(negedge clk);
        out_en = 1;
        for (int i = 0; i < 193; i++) begin
            @(posedge clk); #2;
            got[i] = out_bit;
            syn[i] = out_sync;
        end
        if (!keep_on) begin
            @(negedge clk);
            out_en = 0;
        end
        check(got == exp, req, "frame data", got, exp);
        check(syn == syn_exp && got[0] == 1'b1, "R4/R5", "sync position", syn, syn_exp);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        ifr_t f, g;
        logic [31:0] m;
        void'($urandom(32'd4242));
        rst = 1; in_en = 0; in_sync = 0; in_bit = 0; out_en = 0;
        reg_wr_en = 0; reg_addr = 0; reg_wr_data = 0;
        repeat (5) @(posedge clk);
        #2;
        check(out_bit == 1'b1 && out_sync == 1'b0, "R9", "reset outputs",
              {out_bit, out_sync}, 193'b10);
        @(negedge clk); rst = 0;

        // R9: nothing captured yet -> all ones
        recv_check("R9", {193{1'b1}}, 0);

        // R2: reset mask maps timeslots 1..24 straight through
        f = rand_frame();
        send_frame(f, -1, 0, 0);
        recv_check("R2", to_bits(ofr_t'(f[23:0])), 1);
        // R5: back-to-back output frame, same pending image
        recv_check("R5", to_bits(ofr_t'(f[23:0])), 0);

        // R1 R3: example mask 01,00,01,FC
        set_mask(32'hFC01_0001);
        f = rand_frame();
        send_frame(f, -1, 0, 0);
        recv_check("R1", to_bits(ref_pack(f, 32'hFC01_0001)), 0);

        // R6: everything dropped
        set_mask(32'hFFFF_FFFF);
        f = rand_frame();
        send_frame(f, -1, 0, 0);
        recv_check("R6", {193{1'b1}}, 0);

        // R7: everything kept -> first 24
        set_mask(32'h0000_0000);
        f = rand_frame();
        send_frame(f, -1, 0, 0);
        recv_check("R7", to_bits(ofr_t'(f[23:0])), 0);

        // R6: sparse mask keeps 16
        set_mask(32'h5555_5555);
        f = rand_frame();
        send_frame(f, -1, 0, 0);
        recv_check("R6", to_bits(ref_pack(f, 32'h5555_5555)), 0);

        // R8: mid-frame write of byte 3 affects the following frame only
        set_mask(32'hFF00_0000);
        f = rand_frame();
        send_frame(f, 100, 2'd3, 8'h00);
        recv_check("R8", to_bits(ref_pack(f, 32'hFF00_0000)), 0);
        g = rand_frame();
        send_frame(g, -1, 0, 0);
        recv_check("R8", to_bits(ref_pack(g, 32'h0000_0000)), 0);

        // R10: unsynchronised bits, then a framed input realigns
        set_mask(32'h8000_0F01);
        send_garbage(70);
        f = rand_frame();
        send_frame(f, -1, 0, 0);
        recv_check("R10", to_bits(ref_pack(f, 32'h8000_0F01)), 0);

        // R3 R6 R7: random masks and data
        for (int it = 0; it < 10; it++) begin
            m = (it % 2 == 0) ? ($urandom & $urandom) : ($urandom | $urandom);
            set_mask(m);
            f = rand_frame();
            send_frame(f, -1, 0, 0);
            recv_check("R3", to_bits(ref_pack(f, m)), 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule